// File: doc/BRIEF.md
# Single-Channel DMA Stream Controller

This block is one DMA channel that moves words between a peripheral data register and memory, or between two memory regions. Software sets a peripheral-side address, two memory-side base addresses, an item count and a control word through a small register port. Once enabled, the channel moves one item at a time. In the peripheral modes it moves an item only while the peripheral raises its request line. In memory-to-memory mode it moves items back to back with no request. Each item is a read from the source followed by a write to the destination, over a single-beat command/response bus that can answer with an error.

Three run modes exist. In normal mode the channel stops after N items. In circular mode it reloads its count and pointers and keeps going. In double-buffer mode it swaps between two memory bases on every wrap, and a current-target bit shows which buffer is now being filled or drained. Sticky flags report half-way, completion and bus error. Software clears them by writing ones to a separate clear register. One interrupt line combines the flags whose enables are set.

The command channel is valid/ready. While `cmd_valid` is high and `cmd_ready` is low, the channel holds the address, write flag and write data unchanged. Only one command is outstanding at a time. Exactly one response follows each accepted command, no earlier than the next cycle. The channel always accepts responses, so the response side has no ready signal.

Top module: `dma_channel`

## Requirements
- R1: Register offsets are 0 control, 1 peripheral address, 2 memory base 0, 3 memory base 1, 4 count (reads return the remaining count), 5 status, 6 clear. Control bits are bit0 enable, bit1 direction, bit2 memory-to-memory, bit3 increment, bit4 circular, bit5 double-buffer, bit6 current target, bit7 complete-irq enable, bit8 half-irq enable, bit9 error-irq enable. Status and clear bits are bit0 complete, bit1 half, bit2 error. After reset every register reads 0, `cmd_valid` is low and `irq` is low.
- R2: When the increment bit is set, the memory-side pointer advances by DW/8 after each item and the peripheral-side address stays fixed. In memory-to-memory mode the peripheral-address register is the source, and it advances as well.
- R3: Direction 0 reads from the peripheral address and writes to memory. Direction 1 reads from memory and writes to the peripheral address. Outside memory-to-memory mode, no item starts while `periph_req` is low.
- R4: In normal mode, after the N-th item the complete flag is set, the enable bit clears, the count reads 0 and no further command is issued.
- R5: In circular mode, after the N-th item the count and the memory pointer reload to their programmed values and transfers continue with the enable bit still set.
- R6: The half flag is set when floor(N/2) items of the current pass have moved, provided N is at least 2.
- R7: In double-buffer mode each wrap flips the current-target bit and restarts at the other memory base. Enabling starts at base 1 when the current-target bit is written as 1, and at base 0 otherwise.
- R8: An error response sets the error flag, clears the enable bit, issues no further commands and leaves the remaining count unchanged.
- R9: Writing 1 to a clear bit clears that status flag. If hardware sets the same flag in the same cycle, the flag stays set.
- R10: Writes to the peripheral-address, memory-base and count registers are ignored while the channel is enabled.
- R11: Enabling with a count of 0 sets the complete flag at once, leaves the enable bit clear and issues no command.
- R12: `irq` is high exactly when some status flag is set together with its enable bit.
- R13: A command held without `cmd_ready` keeps its address, write flag and data stable. Data moves correctly under any pattern of back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| periph_req | input | 1 | Peripheral request, level sensitive |
| cmd_valid | output | 1 | Bus command valid |
| cmd_ready | input | 1 | Bus command accepted |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | AW | Bus byte address |
| cmd_wdata | output | DW | Write data |
| rsp_valid | input | 1 | Bus response valid |
| rsp_rdata | input | DW | Read response data |
| rsp_err | input | 1 | Error response |
| irq | output | 1 | Interrupt request |

## Verification
The risky overlap is a software clear of the complete flag that arrives in the same cycle as the final write response that sets that flag. The bench first leaves the complete flag set from an earlier run. It then starts a one-item copy, watches for the write command and issues the clear write so that it lands on the response edge. The flag must still read as set afterwards, and a clear with no collision must take effect. A second overlap, a register write during a wrap, is checked by an assertion that the current-target bit changes only in double-buffer mode.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  localparam int RW  = 32;
  localparam int RAW = 3;

  localparam logic [RAW-1:0] OFS_CTRL   = 3'd0;
  localparam logic [RAW-1:0] OFS_PADDR  = 3'd1;
  localparam logic [RAW-1:0] OFS_MBASE0 = 3'd2;
  localparam logic [RAW-1:0] OFS_MBASE1 = 3'd3;
  localparam logic [RAW-1:0] OFS_COUNT  = 3'd4;
  localparam logic [RAW-1:0] OFS_STATUS = 3'd5;
  localparam logic [RAW-1:0] OFS_CLEAR  = 3'd6;

  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_M2M  = 2;
  localparam int CB_INC  = 3;
  localparam int CB_CIRC = 4;
  localparam int CB_DBUF = 5;
  localparam int CB_CT   = 6;
  localparam int CB_IE0  = 7;

  localparam int NFLAG  = 3;
  localparam int FL_TC  = 0;
  localparam int FL_HT  = 1;
  localparam int FL_TE  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CMD, ST_RD_WAIT, ST_WR_CMD, ST_WR_WAIT
  } eng_st_e;
endpackage

// File: rtl/dma_ch_engine.sv
module dma_ch_engine
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          free_run,
  input  logic          periph_req,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_write,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  input  logic          rsp_err,
  output logic          item_done,
  output logic          xfer_err,
  output logic          busy
);
  eng_st_e       st_q;
  logic [DW-1:0] hold_q;
  logic          in_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:    if (run && (free_run || periph_req)) st_q <= ST_RD_CMD;
        ST_RD_CMD:  if (cmd_ready) st_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_valid) begin
                      if (rsp_err) st_q <= ST_IDLE;
                      else begin
                        hold_q <= rsp_rdata;
                        st_q   <= ST_WR_CMD;
                      end
                    end
        ST_WR_CMD:  if (cmd_ready) st_q <= ST_WR_WAIT;
        ST_WR_WAIT: if (rsp_valid) st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_wait   = (st_q == ST_RD_WAIT) || (st_q == ST_WR_WAIT);
  assign cmd_valid = (st_q == ST_RD_CMD) || (st_q == ST_WR_CMD);
  assign cmd_write = (st_q == ST_WR_CMD);
  assign cmd_addr  = cmd_write ? dst_addr : src_addr;
  assign cmd_wdata = hold_q;
  assign item_done = (st_q == ST_WR_WAIT) && rsp_valid && !rsp_err;
  assign xfer_err  = in_wait && rsp_valid && rsp_err;
  assign busy      = (st_q != ST_IDLE);
endmodule

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [RW-1:0]    reg_wdata,
  output logic [RW-1:0]    reg_rdata,
  input  logic             item_done,
  input  logic             xfer_err,
  input  logic             busy,
  output logic             en,
  output logic             dir,
  output logic             m2m,
  output logic [AW-1:0]    cur_paddr,
  output logic [AW-1:0]    cur_maddr,
  output logic             ct,
  output logic             dbuf,
  output logic [CW-1:0]    rem,
  output logic [CW-1:0]    nprog,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic             en_q, dir_q, m2m_q, inc_q, circ_q, dbuf_q, ct_q;
  logic [NFLAG-1:0] ie_q, flag_q, flag_d, flag_set, flag_clr;
  logic [AW-1:0]    pbase_q, mb0_q, mb1_q, curp_q, curm_q;
  logic [CW-1:0]    nprog_q, rem_q, rem_dec;
  logic             locked, wr_ctrl, start_ok, zero_start, wrap, half_hit, reload;

  assign locked     = en_q || busy;
  assign wr_ctrl    = reg_we && (reg_addr == OFS_CTRL);
  assign start_ok   = wr_ctrl && !locked && reg_wdata[CB_EN];
  assign zero_start = start_ok && (nprog_q == '0);
  assign rem_dec    = rem_q - CW'(1);
  assign wrap       = item_done && (rem_q == CW'(1));
  assign half_hit   = item_done && (nprog_q >= CW'(2)) &&
                      (rem_dec == (nprog_q - (nprog_q >> 1)));
  assign reload     = circ_q || dbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; dir_q <= 1'b0; m2m_q <= 1'b0; inc_q <= 1'b0;
      circ_q <= 1'b0; dbuf_q <= 1'b0; ct_q <= 1'b0; ie_q <= '0;
      pbase_q <= '0; mb0_q <= '0; mb1_q <= '0;
      curp_q <= '0; curm_q <= '0; nprog_q <= '0; rem_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ie_q <= reg_wdata[CB_IE0 +: NFLAG];
        if (!locked) begin
          dir_q  <= reg_wdata[CB_DIR];
          m2m_q  <= reg_wdata[CB_M2M];
          inc_q  <= reg_wdata[CB_INC];
          circ_q <= reg_wdata[CB_CIRC];
          dbuf_q <= reg_wdata[CB_DBUF];
          ct_q   <= reg_wdata[CB_CT];
          en_q   <= reg_wdata[CB_EN] && (nprog_q != '0);
          if (reg_wdata[CB_EN]) begin
            curp_q <= pbase_q;
            curm_q <= reg_wdata[CB_CT] ? mb1_q : mb0_q;
            rem_q  <= nprog_q;
          end
        end else begin
          en_q <= en_q && reg_wdata[CB_EN];
        end
      end
      if (reg_we && !locked) begin
        unique case (reg_addr)
          OFS_PADDR:  pbase_q <= reg_wdata[AW-1:0];
          OFS_MBASE0: mb0_q   <= reg_wdata[AW-1:0];
          OFS_MBASE1: mb1_q   <= reg_wdata[AW-1:0];
          OFS_COUNT: begin
            nprog_q <= reg_wdata[CW-1:0];
            rem_q   <= reg_wdata[CW-1:0];
          end
          default: ;
        endcase
      end
      if (item_done) begin
        if (wrap && reload) begin
          rem_q  <= nprog_q;
          curp_q <= pbase_q;
          if (dbuf_q) begin
            ct_q   <= !ct_q;
            curm_q <= ct_q ? mb0_q : mb1_q;
          end else begin
            curm_q <= ct_q ? mb1_q : mb0_q;
          end
        end else begin
          rem_q <= rem_dec;
          if (inc_q) curm_q <= curm_q + STEP;
          if (inc_q && m2m_q) curp_q <= curp_q + STEP;
        end
        if (wrap && !reload) en_q <= 1'b0;
      end
      if (xfer_err) en_q <= 1'b0;
    end
  end

  assign flag_set[FL_TC] = wrap || zero_start;
  assign flag_set[FL_HT] = half_hit;
  assign flag_set[FL_TE] = xfer_err;
  assign flag_clr = (reg_we && (reg_addr == OFS_CLEAR)) ? reg_wdata[NFLAG-1:0] : '0;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flag_d[i] = (flag_q[i] && !flag_clr[i]) || flag_set[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CB_EN]   = en_q;
        reg_rdata[CB_DIR]  = dir_q;
        reg_rdata[CB_M2M]  = m2m_q;
        reg_rdata[CB_INC]  = inc_q;
        reg_rdata[CB_CIRC] = circ_q;
        reg_rdata[CB_DBUF] = dbuf_q;
        reg_rdata[CB_CT]   = ct_q;
        reg_rdata[CB_IE0 +: NFLAG] = ie_q;
      end
      OFS_PADDR:  reg_rdata = RW'(pbase_q);
      OFS_MBASE0: reg_rdata = RW'(mb0_q);
      OFS_MBASE1: reg_rdata = RW'(mb1_q);
      OFS_COUNT:  reg_rdata = RW'(rem_q);
      OFS_STATUS: reg_rdata = RW'(flag_q);
      default:    reg_rdata = '0;
    endcase
  end

  assign en        = en_q;
  assign dir       = dir_q;
  assign m2m       = m2m_q;
  assign cur_paddr = curp_q;
  assign cur_maddr = curm_q;
  assign ct        = ct_q;
  assign dbuf      = dbuf_q;
  assign rem       = rem_q;
  assign nprog     = nprog_q;
  assign flags     = flag_q;
  assign irq       = |(flag_q & ie_q);
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          periph_req,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_write,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  input  logic          rsp_err,
  output logic          irq
);
  logic             en_w, dir_w, m2m_w, ct_w, dbuf_w;
  logic             item_done_w, xfer_err_w, busy_w, to_periph;
  logic [AW-1:0]    curp_w, curm_w, src_w, dst_w;
  logic [CW-1:0]    rem_w, nprog_w;
  logic [NFLAG-1:0] flags_w;

  dma_ch_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .item_done(item_done_w), .xfer_err(xfer_err_w), .busy(busy_w),
    .en(en_w), .dir(dir_w), .m2m(m2m_w),
    .cur_paddr(curp_w), .cur_maddr(curm_w),
    .ct(ct_w), .dbuf(dbuf_w), .rem(rem_w), .nprog(nprog_w),
    .flags(flags_w), .irq(irq)
  );

  assign to_periph = dir_w && !m2m_w;
  assign src_w     = to_periph ? curm_w : curp_w;
  assign dst_w     = to_periph ? curp_w : curm_w;

  dma_ch_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .run(en_w), .free_run(m2m_w), .periph_req(periph_req),
    .src_addr(src_w), .dst_addr(dst_w),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .item_done(item_done_w), .xfer_err(xfer_err_w), .busy(busy_w)
  );
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_write,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] cmd_wdata,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          en,
  input logic          busy,
  input logic          ct,
  input logic          dbuf,
  input logic [CW-1:0] rem,
  input logic [CW-1:0] nprog,
  input logic          tc
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_write) && $stable(cmd_wdata)); // R13
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_valid && rsp_valid && rsp_err |=> !en); // R8
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= nprog); // R10
  AST_CT_ONLY_DBUF: assert property (@(posedge clk) disable iff (!rst_n)
    en && !dbuf |=> $stable(ct)); // R7
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tc && !(reg_we && reg_addr == OFS_CLEAR && reg_wdata[FL_TC]) |=> tc); // R9
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !busy |=> !cmd_valid); // R4
endmodule

bind dma_channel dma_channel_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .en(en_w), .busy(busy_w), .ct(ct_w), .dbuf(dbuf_w),
  .rem(rem_w), .nprog(nprog_w), .tc(flags_w[0])
);

// File: tb/dma_channel_tb_top.sv
`timescale 1ns/1ps
module dma_channel_tb_top;
  localparam logic [31:0] DEV = 32'h1000_0000;
  localparam logic [31:0] PV  = 32'hA000_0000;
  localparam logic [2:0] A_CTRL = 0, A_PADDR = 1, A_MB0 = 2, A_MB1 = 3,
                         A_CNT = 4, A_STAT = 5, A_CLR = 6;
  localparam logic [31:0] C_EN = 1, C_DIR = 2, C_M2M = 4, C_INC = 8, C_CIRC = 16,
                          C_DBUF = 32, C_CT = 64, C_TCIE = 128, C_HTIE = 256, C_TEIE = 512;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic periph_req = 0;
  logic cmd_valid, cmd_ready, cmd_write;
  logic [31:0] cmd_addr, cmd_wdata;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic irq;
  logic stall = 0;
  int unsigned cyc = 0;
  int n_chk = 0, n_bad = 0;
  int prd_n = 0, plog_n = 0;
  logic [31:0] mem [0:255];
  logic [31:0] plog [0:15];

  always #4 clk = !clk;

  dma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
  );

  assign cmd_ready = stall ? cyc[0] : 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 0; rsp_err <= 0; rsp_rdata <= 0;
    end else begin
      rsp_valid <= 0; rsp_err <= 0;
      if (cmd_valid && cmd_ready) begin
        rsp_valid <= 1;
        if (cmd_addr == DEV) begin
          if (cmd_write) begin
            if (plog_n < 16) plog[plog_n] <= cmd_wdata;
            plog_n <= plog_n + 1;
          end else begin
            rsp_rdata <= PV + prd_n;
            prd_n <= prd_n + 1;
          end
        end else if (cmd_addr < 32'h400) begin
          if (cmd_write) mem[cmd_addr[9:2]] <= cmd_wdata;
          else rsp_rdata <= mem[cmd_addr[9:2]];
        end else begin
          rsp_err <= 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_stop();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); rd(A_CTRL, v);
      if (!v[0]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] pa, input logic [31:0] m0, input logic [31:0] m1, input logic [31:0] n);
    wr(A_PADDR, pa); wr(A_MB0, m0); wr(A_MB1, m1); wr(A_CNT, n);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    chk("R1 reset cmd_valid", {31'b0, cmd_valid}, 0);
    chk("R1 reset irq", {31'b0, irq}, 0);
    rd(A_CTRL, v); chk("R1 reset ctrl", v, 0);
    rd(A_CNT, v);  chk("R1 reset count", v, 0);
    rd(A_STAT, v); chk("R1 reset status", v, 0);
  endtask

  task automatic t_m2m_normal();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) mem[8'h40 + i] = 32'h1111_0000 + i;
    setup(32'h100, 32'h200, 0, 4);
    stall = 1;
    wr(A_CTRL, C_EN | C_M2M | C_INC | C_TCIE);
    wait_stop();
    stall = 0;
    for (int i = 0; i < 4; i++) chk("R2 R13 m2m copy under back-pressure", mem[8'h80 + i], 32'h1111_0000 + i);
    rd(A_STAT, v); chk("R4 R6 m2m flags", v, 3);
    rd(A_CTRL, v); chk("R4 enable cleared", v & C_EN, 0);
    rd(A_CNT, v);  chk("R4 count zero", v, 0);
    chk("R12 irq on complete", {31'b0, irq}, 1);
    wr(A_CLR, 7);
  endtask

  task automatic t_mem_to_periph();
    logic [31:0] v;
    int n0;
    for (int i = 0; i < 3; i++) mem[8'h50 + i] = 32'h2222_0000 + i;
    setup(DEV, 32'h140, 0, 3);
    n0 = plog_n;
    wr(A_CTRL, C_EN | C_DIR | C_INC);
    periph_req = 1;
    wait_stop();
    periph_req = 0;
    chk("R2 fixed device address count", plog_n - n0, 3);
    for (int i = 0; i < 3; i++) chk("R3 mem to periph data", plog[n0 + i], 32'h2222_0000 + i);
    rd(A_STAT, v); chk("R6 half at floor(3/2)", v, 3);
    wr(A_CLR, 7);
  endtask

  task automatic t_periph_to_mem();
    int p0;
    setup(DEV, 32'h180, 0, 2);
    p0 = prd_n;
    wr(A_CTRL, C_EN | C_INC);
    periph_req = 1;
    wait_stop();
    periph_req = 0;
    for (int i = 0; i < 2; i++) chk("R3 periph to mem data", mem[8'h60 + i], PV + p0 + i);
    wr(A_CLR, 7);
  endtask

  task automatic t_no_req_and_lock();
    logic [31:0] v;
    int seen = 0, p0;
    setup(DEV, 32'h1C0, 0, 2);
    wr(A_CTRL, C_EN | C_INC);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (cmd_valid) seen++; end
    chk("R3 no command without request", seen, 0);
    wr(A_PADDR, 32'h55); wr(A_MB0, 32'h77); wr(A_CNT, 9);
    rd(A_PADDR, v); chk("R10 paddr locked", v, DEV);
    rd(A_MB0, v);   chk("R10 mbase0 locked", v, 32'h1C0);
    rd(A_CNT, v);   chk("R10 count locked", v, 2);
    p0 = prd_n;
    periph_req = 1;
    wait_stop();
    periph_req = 0;
    chk("R10 data at original base", mem[8'h70], PV + p0);
    wr(A_CLR, 7);
  endtask

  task automatic t_zero_count();
    logic [31:0] v;
    int seen = 0;
    wr(A_CNT, 0);
    wr(A_CTRL, C_EN | C_M2M | C_INC);
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (cmd_valid) seen++; end
    chk("R11 zero count no command", seen, 0);
    rd(A_STAT, v); chk("R11 zero count complete", v, 1);
    rd(A_CTRL, v); chk("R11 zero count not enabled", v & C_EN, 0);
    wr(A_CLR, 7);
  endtask

  task automatic t_circular();
    logic [31:0] v;
    int p0;
    setup(DEV, 32'h200, 0, 4);
    p0 = prd_n;
    wr(A_CTRL, C_EN | C_INC | C_CIRC);
    periph_req = 1;
    while (prd_n - p0 < 6) @(negedge clk);
    periph_req = 0;
    repeat (10) @(negedge clk);
    chk("R5 wrap item 4", mem[8'h80], PV + p0 + 4);
    chk("R5 wrap item 5", mem[8'h81], PV + p0 + 5);
    chk("R5 first pass kept", mem[8'h82], PV + p0 + 2);
    rd(A_CNT, v);  chk("R5 count reloaded", v, 2);
    rd(A_CTRL, v); chk("R5 still enabled", v & C_EN, 1);
    rd(A_STAT, v); chk("R5 flags", v, 3);
    wr(A_CTRL, 0);
    repeat (4) @(negedge clk);
    rd(A_CTRL, v); chk("R5 software stop", v & C_EN, 0);
    wr(A_CLR, 7);
  endtask

  task automatic t_double_buffer();
    logic [31:0] v;
    int p0;
    setup(DEV, 32'h100, 32'h180, 2);
    p0 = prd_n;
    wr(A_CTRL, C_EN | C_INC | C_DBUF);
    periph_req = 1;
    while (prd_n - p0 < 3) @(negedge clk);
    periph_req = 0;
    repeat (10) @(negedge clk);
    chk("R7 buffer0 item0", mem[8'h40], PV + p0);
    chk("R7 buffer0 item1", mem[8'h41], PV + p0 + 1);
    chk("R7 buffer1 item0", mem[8'h60], PV + p0 + 2);
    rd(A_CTRL, v); chk("R7 current target", v & C_CT, C_CT);
    rd(A_CNT, v);  chk("R7 count", v, 1);
    wr(A_CTRL, 0);
    repeat (4) @(negedge clk);
    wr(A_CLR, 7);
  endtask

  task automatic t_error();
    logic [31:0] v;
    mem[8'h40] = 32'hCAFE_0001; mem[8'h41] = 32'hCAFE_0002;
    setup(32'h100, 32'h3FC, 0, 4);
    wr(A_CTRL, C_EN | C_M2M | C_INC | C_TEIE);
    wait_stop();
    chk("R8 first item written", mem[8'hFF], 32'hCAFE_0001);
    rd(A_STAT, v); chk("R8 error flag only", v, 4);
    rd(A_CNT, v);  chk("R8 remaining kept", v, 3);
    chk("R12 irq on error", {31'b0, irq}, 1);
    chk("R8 no command after error", {31'b0, cmd_valid}, 0);
    wr(A_CLR, 7);
  endtask

  task automatic t_clear_irq();
    logic [31:0] v;
    mem[8'h40] = 1; mem[8'h41] = 2;
    setup(32'h100, 32'h200, 0, 2);
    wr(A_CTRL, C_EN | C_M2M | C_INC);
    wait_stop();
    chk("R12 irq off with no enables", {31'b0, irq}, 0);
    wr(A_CTRL, C_HTIE);
    chk("R12 irq half enabled", {31'b0, irq}, 1);
    wr(A_CLR, 1);
    rd(A_STAT, v); chk("R9 clear complete only", v, 2);
    chk("R12 irq still half", {31'b0, irq}, 1);
    wr(A_CLR, 2);
    rd(A_STAT, v); chk("R9 clear half", v, 0);
    chk("R12 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    mem[8'h40] = 32'h5A5A_0001;
    setup(32'h100, 32'h200, 0, 1);
    wr(A_CTRL, C_EN | C_M2M | C_INC);
    wait_stop();
    rd(A_STAT, v); chk("R4 single item complete", v, 1);
    wr(A_CTRL, C_EN | C_M2M | C_INC);
    for (int i = 0; i < 50; i++) begin
      if (cmd_valid && cmd_write) break;
      @(negedge clk);
    end
    wr(A_CLR, 1);
    @(negedge clk);
    rd(A_STAT, v); chk("R9 set wins over clear", v, 1);
    wr(A_CLR, 1);
    rd(A_STAT, v); chk("R9 plain clear", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_m2m_normal();
    t_mem_to_periph();
    t_periph_to_mem();
    t_no_req_and_lock();
    t_zero_count();
    t_circular();
    t_double_buffer();
    t_error();
    t_clear_irq();
    t_collision();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule